// File: doc/BRIEF.md
# Built-In-Test Fault Monitor

This block merges the health conditions of a tracking angle converter into one active-low built-in-test line. It watches digitised sine, cosine and reference amplitudes, a signed tracking-error word in LSBs, and a phase-inversion flag. The phase-inversion flag is raised when the signal is in anti-phase with the reference, so the tracking loop has settled on the wrong null.

Amplitude losses and phase inversion pull the output low at once. An excessive tracking error must persist for a programmable number of cycles before it counts. After reset the output stays asserted until the tracking error first falls inside its limit. A phase inversion also sends a one-cycle kickstart pulse to the angle counter, which pushes the loop out of the false null.

Top module: `bit_fault_monitor`

## Requirements
- R1: While rst_ni is low, bit_no is 0 (fault indicated) and kick_o is 0.
- R2: If sin_mag_i and cos_mag_i are both below AMP_THR at a clock edge, bit_no is 0 after that edge. If only one of them is below AMP_THR, no signal-loss fault is raised.
- R3: If ref_mag_i is below AMP_THR at a clock edge, bit_no is 0 after that edge. A value equal to AMP_THR is not a loss.
- R4: A signal-loss or reference-loss fault clears after the first edge at which its condition no longer holds, with no delay.
- R5: An excess-error fault (|trk_err_i| > ERR_THR) lowers bit_no only after DLY_CYC consecutive edges with excess error. bit_no goes low exactly after the DLY_CYC-th edge.
- R6: One edge with the error within limit during the qualifying window restarts the count from zero.
- R7: The excess-error fault clears after the first edge at which |trk_err_i| <= ERR_THR.
- R8: After reset, bit_no stays 0 until the first edge at which |trk_err_i| <= ERR_THR.
- R9: While false_null_i is 1 at an edge, bit_no is 0 after that edge. The fault clears after the first edge at which false_null_i is 0.
- R10: kick_o is a single-cycle pulse. It goes high after each edge at which false_null_i is 1 and was 0 at the previous edge, and it does not repeat while false_null_i stays high.
- R11: The error limit uses the two's-complement magnitude. Negative errors behave like positive ones, |trk_err_i| equal to ERR_THR is within limit, and the most negative code counts as excess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sin_mag_i | input | AMP_W | Sine channel amplitude, unsigned |
| cos_mag_i | input | AMP_W | Cosine channel amplitude, unsigned |
| ref_mag_i | input | AMP_W | Reference amplitude, unsigned |
| trk_err_i | input | ERR_W | Signed tracking error in LSBs |
| false_null_i | input | 1 | Signal in anti-phase with the reference |
| bit_no | output | 1 | Built-in-test, low on any fault |
| kick_o | output | 1 | One-cycle kickstart to the angle counter |

## Verification
The bench holds an excess error for DLY_CYC-1 edges and then for one more edge. A design off by one in its delay counter would drop bit_no a cycle early or a cycle late. It also breaks an excess-error run with a single in-limit edge, which catches a counter that pauses instead of restarting, and it feeds errors exactly at the limit, negative errors and the most negative code, which catch a non-strict comparison or a magnitude that wraps. Finally it holds false_null_i high over several cycles and raises it a second time: a level-driven kick would repeat, and an edge detector that never re-arms would miss the second rise.

// File: rtl/bit_mon_pkg.sv
package bit_mon_pkg;

  typedef struct packed {
    logic los;
    logic lor;
    logic err;
    logic unsettled;
    logic fnull;
  } fault_t;

  function automatic logic any_fault(fault_t f);
    return f.los | f.lor | f.err | f.unsettled | f.fnull;
  endfunction

endpackage

// File: rtl/amp_loss_det.sv
// Registered flag: every channel magnitude below threshold.
module amp_loss_det #(
  parameter int unsigned AMP_W   = 12,
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned AMP_THR = 410
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0][AMP_W-1:0]   mag_i,
  output logic                           loss_o
);

  localparam logic [AMP_W-1:0] THR_V = AMP_W'(AMP_THR);

  logic [NUM_CH-1:0] low_ch;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign low_ch[g] = (mag_i[g] < THR_V);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loss_o <= 1'b0;
    else         loss_o <= &low_ch;
  end

endmodule

// File: rtl/err_qual.sv
// Excess-error qualifier with restartable delay and power-up settle flag.
module err_qual #(
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned ERR_THR = 100,
  parameter int unsigned DLY_CYC = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    err_o,
  output logic                    unsettled_o
);

  localparam int unsigned   CNT_W = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC);
  localparam logic [ERR_W-1:0] THR_V = ERR_W'(ERR_THR);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DLY_CYC - 1);

  logic [ERR_W-1:0] mag;
  logic             over;
  logic [CNT_W-1:0] cnt_q;

  // two's-complement magnitude, unsigned so the most negative code is exact
  assign mag  = err_i[ERR_W-1] ? (~err_i + 1'b1) : err_i;
  assign over = (mag > THR_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_o <= 1'b0;
    end else if (!over) begin
      cnt_q <= '0;
      err_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      err_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    unsettled_o <= 1'b1;
    else if (!over) unsettled_o <= 1'b0;
  end

endmodule

// File: rtl/fnull_kick.sv
// Phase-inversion flag register and rising-edge kick pulse.
module fnull_kick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fnull_i,
  output logic fnull_o,
  output logic kick_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fnull_o <= 1'b0;
      kick_o  <= 1'b0;
    end else begin
      fnull_o <= fnull_i;
      kick_o  <= fnull_i & ~fnull_o;
    end
  end

endmodule

// File: rtl/bit_fault_monitor.sv
module bit_fault_monitor
  import bit_mon_pkg::*;
#(
  parameter int unsigned AMP_W   = 12,
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned AMP_THR = 410,
  parameter int unsigned ERR_THR = 100,
  parameter int unsigned DLY_CYC = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AMP_W-1:0]        sin_mag_i,
  input  logic [AMP_W-1:0]        cos_mag_i,
  input  logic [AMP_W-1:0]        ref_mag_i,
  input  logic signed [ERR_W-1:0] trk_err_i,
  input  logic                    false_null_i,
  output logic                    bit_no,
  output logic                    kick_o
);

  fault_t flt;

  amp_loss_det #(.AMP_W(AMP_W), .NUM_CH(2), .AMP_THR(AMP_THR)) u_los (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mag_i  ({sin_mag_i, cos_mag_i}),
    .loss_o (flt.los)
  );

  amp_loss_det #(.AMP_W(AMP_W), .NUM_CH(1), .AMP_THR(AMP_THR)) u_lor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mag_i  (ref_mag_i),
    .loss_o (flt.lor)
  );

  err_qual #(.ERR_W(ERR_W), .ERR_THR(ERR_THR), .DLY_CYC(DLY_CYC)) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_i       (trk_err_i),
    .err_o       (flt.err),
    .unsettled_o (flt.unsettled)
  );

  fnull_kick u_fn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fnull_i (false_null_i),
    .fnull_o (flt.fnull),
    .kick_o  (kick_o)
  );

  assign bit_no = ~any_fault(flt);

endmodule

// File: rtl/bit_mon_chk.sv
module bit_mon_chk #(
  parameter int unsigned AMP_W   = 12,
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned AMP_THR = 410,
  parameter int unsigned ERR_THR = 100,
  parameter int unsigned DLY_CYC = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [AMP_W-1:0]        sin_mag_i,
  input logic [AMP_W-1:0]        cos_mag_i,
  input logic [AMP_W-1:0]        ref_mag_i,
  input logic signed [ERR_W-1:0] trk_err_i,
  input logic                    false_null_i,
  input logic                    bit_no,
  input logic                    kick_o
);

  localparam int unsigned CW = $clog2(DLY_CYC + 1) + 1;

  logic [ERR_W-1:0] mag;
  logic             over;
  logic [CW-1:0]    run_q;

  assign mag  = trk_err_i[ERR_W-1] ? (~trk_err_i + 1'b1) : trk_err_i;
  assign over = (mag > ERR_W'(ERR_THR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= '0;
    else if (!over)                 run_q <= '0;
    else if (run_q < CW'(DLY_CYC))  run_q <= run_q + 1'b1;
  end

  // R2
  los_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_mag_i < AMP_W'(AMP_THR) && cos_mag_i < AMP_W'(AMP_THR)) |=> !bit_no);

  // R3
  lor_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_mag_i < AMP_W'(AMP_THR)) |=> !bit_no);

  // R5
  err_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= CW'(DLY_CYC)) |-> !bit_no);

  // R9
  fnull_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_null_i |=> !bit_no);

  // R10
  kick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o);

  // R10
  kick_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kick_o) |-> $past(false_null_i));

  // R4
  clean_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!over && !false_null_i && ref_mag_i >= AMP_W'(AMP_THR) &&
     (sin_mag_i >= AMP_W'(AMP_THR) || cos_mag_i >= AMP_W'(AMP_THR))) |=> bit_no);

endmodule

bind bit_fault_monitor bit_mon_chk #(
  .AMP_W(AMP_W), .ERR_W(ERR_W), .AMP_THR(AMP_THR), .ERR_THR(ERR_THR), .DLY_CYC(DLY_CYC)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sin_mag_i    (sin_mag_i),
  .cos_mag_i    (cos_mag_i),
  .ref_mag_i    (ref_mag_i),
  .trk_err_i    (trk_err_i),
  .false_null_i (false_null_i),
  .bit_no       (bit_no),
  .kick_o       (kick_o)
);

// File: tb/bit_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module bit_fault_monitor_tb_top;

  localparam int unsigned AMP_W   = 12;
  localparam int unsigned ERR_W   = 16;
  localparam int unsigned AMP_THR = 410;
  localparam int unsigned ERR_THR = 100;
  localparam int unsigned DLY     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AMP_W-1:0] sin_m, cos_m, ref_m;
  logic signed [ERR_W-1:0] err;
  logic fnull;
  logic bit_n, kick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bit_fault_monitor #(
    .AMP_W(AMP_W), .ERR_W(ERR_W), .AMP_THR(AMP_THR), .ERR_THR(ERR_THR), .DLY_CYC(DLY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sin_mag_i(sin_m), .cos_mag_i(cos_m),
    .ref_mag_i(ref_m), .trk_err_i(err), .false_null_i(fnull),
    .bit_no(bit_n), .kick_o(kick)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, sample shortly after it
  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_clean();
    sin_m = 12'd2000; cos_m = 12'd2000; ref_m = 12'd2000;
    err = '0; fnull = 1'b0;
  endtask

  task automatic t_reset();
    set_clean();
    err = 16'sd500;
    step(2);
    chk(bit_n, 1'b0, "R1 bit in reset");
    chk(kick,  1'b0, "R1 kick in reset");
    rst_n = 1'b1;
    step(3);
    chk(bit_n, 1'b0, "R8 held until settle");
    err = 16'sd0;
    step();
    chk(bit_n, 1'b1, "R8 release on settle");
  endtask

  task automatic t_los();
    sin_m = 12'd100; cos_m = 12'd100;
    step();
    chk(bit_n, 1'b0, "R2 both low");
    sin_m = 12'd1000;
    step();
    chk(bit_n, 1'b1, "R2 one low / R4 clear");
    sin_m = 12'd100; cos_m = 12'd1000;
    step();
    chk(bit_n, 1'b1, "R2 other one low");
    set_clean();
    step();
  endtask

  task automatic t_lor();
    ref_m = 12'd10;
    step();
    chk(bit_n, 1'b0, "R3 ref low");
    ref_m = 12'(AMP_THR);
    step();
    chk(bit_n, 1'b1, "R3 ref at threshold / R4 clear");
    set_clean();
    step();
  endtask

  task automatic t_err();
    err = 16'sd101;
    for (int i = 0; i < DLY - 1; i++) begin
      step();
      chk(bit_n, 1'b1, "R5 within delay");
    end
    step();
    chk(bit_n, 1'b0, "R5 after delay");
    err = 16'sd0;
    step();
    chk(bit_n, 1'b1, "R7 clear");
  endtask

  task automatic t_restart();
    err = -16'sd150;
    step(DLY - 2);
    err = 16'sd50;
    step();
    chk(bit_n, 1'b1, "R6 dip");
    err = -16'sd150;
    for (int i = 0; i < DLY - 1; i++) begin
      step();
      chk(bit_n, 1'b1, "R6 restarted count");
    end
    step();
    chk(bit_n, 1'b0, "R11 negative excess");
    err = 16'sd0;
    step();
  endtask

  task automatic t_thr();
    err = 16'sd100;
    step(DLY + 4);
    chk(bit_n, 1'b1, "R11 +limit ok");
    err = -16'sd100;
    step(DLY + 4);
    chk(bit_n, 1'b1, "R11 -limit ok");
    err = 16'sh8000;
    step(DLY);
    chk(bit_n, 1'b0, "R11 most negative");
    err = 16'sd0;
    step();
    chk(bit_n, 1'b1, "R7 clear after most negative");
  endtask

  task automatic t_fnull();
    fnull = 1'b1;
    step();
    chk(bit_n, 1'b0, "R9 flag");
    chk(kick,  1'b1, "R10 kick on rise");
    step();
    chk(kick,  1'b0, "R10 kick one cycle");
    chk(bit_n, 1'b0, "R9 held");
    step(3);
    chk(kick,  1'b0, "R10 no repeat");
    fnull = 1'b0;
    step();
    chk(bit_n, 1'b1, "R9 clear");
    chk(kick,  1'b0, "R10 no kick on fall");
    fnull = 1'b1;
    step();
    chk(kick,  1'b1, "R10 second rise");
    fnull = 1'b0;
    step();
    chk(kick,  1'b0, "R10 second pulse ends");
  endtask

  initial begin
    t_reset();
    t_los();
    t_lor();
    t_err();
    t_restart();
    t_thr();
    t_fnull();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule